// File: doc/BRIEF.md
# Prioritized Interrupt Control Unit

This block arbitrates interrupt requests for a small processor core. Five request lines arrive at its inputs: a non-maskable trap, three vectored restart lines of falling priority, and a general request that ranks last. The block also holds the interrupt-enable flag. The core sets this flag by pulsing an enable-instruction strobe and clears it by pulsing a disable-instruction strobe.

The core marks each instruction boundary with a strobe. At such a boundary the block looks for serviceable requests. A request is serviceable if it is the trap, or if it is a maskable line while the enable flag is set. The block takes the highest-ranked serviceable request. One clock later it raises a one-cycle take pulse, which tells the core to push the program counter and jump. With that pulse it presents the index of the chosen source and its fixed vector address. When the general request wins, the vector is zero and an acknowledge pulse asks an outside agent to supply the vector. Taking any interrupt clears the enable flag.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Source indices are trap=0, restart A=1, restart B=2, restart C=3, general=4. When several sources are serviceable at a boundary, the lowest index wins and appears on `src_o`.
- R2: With the take pulse, `vec_o` is 0x24 for index 0, 0x3C for index 1, 0x34 for index 2, 0x2C for index 3 and 0x00 for index 4.
- R3: A high `en_instr_i` sets `ie_o` at the next edge. A high `di_instr_i` clears it at the next edge. If both strobes are high in the same cycle, the disable wins.
- R4: While `ie_o` is low, the restart and general lines are never taken, but a latched trap still is.
- R5: A request is taken only in a cycle where `instr_end_i` is high. `take_o` rises one clock after that cycle.
- R6: The clock edge that takes any interrupt also clears `ie_o`. A maskable line that stays high is therefore not taken again at the next boundary.
- R7: The trap latches only after a low-to-high change of `trap_req_i`, and it is serviceable only while the line stays high. A line already high when reset is released, or a line that falls before the boundary, is not taken. Taking the trap clears its latch.
- R8: A rising edge on `vrq_a_i` is held pending even after the line falls, until the request is taken. Keeping the line high after it has been taken does not request it again.
- R9: `vrq_b_i`, `vrq_c_i` and `gen_req_i` are level-sensitive. A pulse that ends before the boundary is not taken.
- R10: `gen_ack_o` pulses together with `take_o` exactly when the general request is taken.
- R11: After reset, `ie_o`, `take_o` and `gen_ack_o` are low and no request is latched.
- R12: `take_o` and `gen_ack_o` last one cycle. With no new take they are low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_instr_i | input | 1 | Enable-instruction strobe from the core |
| di_instr_i | input | 1 | Disable-instruction strobe from the core |
| instr_end_i | input | 1 | Instruction boundary strobe |
| trap_req_i | input | 1 | Non-maskable trap request, qualified by edge and level |
| vrq_a_i | input | 1 | Restart A request (index 1), edge-latched |
| vrq_b_i | input | 1 | Restart B request (index 2), level |
| vrq_c_i | input | 1 | Restart C request (index 3), level |
| gen_req_i | input | 1 | General request (index 4), level |
| take_o | output | 1 | One-cycle pulse: push the program counter and jump |
| src_o | output | 3 | Index of the source that was taken |
| vec_o | output | 8 | Vector address of the source that was taken |
| gen_ack_o | output | 1 | Acknowledge pulse for the general request |
| ie_o | output | 1 | Interrupt-enable flag |

## Verification
The hardest cases to reach are those where the edge-qualified lines do not match their levels at the boundary. Examples are a trap line held high since before reset ended, a trap edge whose level drops just before the boundary, and a restart A edge that arrived while interrupts were disabled. The bench reaches these by placing reset release, the line edges, the enable strobe and the boundary strobe in chosen cycles. It then holds the lines high after they are taken, so that a second take would show up.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC  = 5;
  localparam int IDX_W = $clog2(NSRC);
  localparam int VEC_W = 8;

  typedef enum logic [IDX_W-1:0] {
    SRC_TRAP = 3'd0,
    SRC_VA   = 3'd1,
    SRC_VB   = 3'd2,
    SRC_VC   = 3'd3,
    SRC_GEN  = 3'd4
  } src_e;

  // trap sits at 0x24; restart lines step down by 8 from 0x3C; general has none
  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
    int v;
    if (idx == SRC_TRAP)     v = 36;
    else if (idx <= SRC_VC)  v = 60 - 8 * (int'(idx) - 1);
    else                     v = 0;
    return VEC_W'(v);
  endfunction
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter bit LEVEL_QUAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q, pend_q, pend_d, rise_w;

  assign rise_w = req_i & ~prev_q;
  assign pend_o = pend_q;

  generate
    if (LEVEL_QUAL) begin : g_lvl
      assign pend_d = req_i & ((pend_q & ~clr_i) | rise_w);
    end else begin : g_edge
      assign pend_d = (pend_q & ~clr_i) | rise_w;
    end
  endgenerate

  // prev resets high so a line already high at reset release is not an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= req_i;
      pend_q <= pend_d;
    end
  end

  generate
    if (LEVEL_QUAL) begin : g_lvl_chk
      // R7
      trap_level_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> $past(req_i));
    end else begin : g_edge_chk
      // R8
      edge_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(req_i));
    end
  endgenerate
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_pkg::*;
(
  input  logic [NSRC-1:0]  cand_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [NSRC-1:0]  grant_o
);
  always_comb begin
    idx_o   = '0;
    grant_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (cand_i[i]) begin
        idx_o   = IDX_W'(i);
        grant_o = '0;
        grant_o[i] = 1'b1;
      end
    end
    any_o = |cand_i;
  end
endmodule

// File: rtl/irq_enable_ff.sv
module irq_enable_ff (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic accept_i,
  output logic ie_o
);
  logic ie_q;
  assign ie_o = ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ie_q <= 1'b0;
    else if (accept_i | clr_i) ie_q <= 1'b0;
    else if (set_i)            ie_q <= 1'b1;
  end

  // R6
  accept_clears_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |=> !ie_o);
  // R3
  disable_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !ie_o);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_instr_i,
  input  logic             di_instr_i,
  input  logic             instr_end_i,
  input  logic             trap_req_i,
  input  logic             vrq_a_i,
  input  logic             vrq_b_i,
  input  logic             vrq_c_i,
  input  logic             gen_req_i,
  output logic             take_o,
  output logic [IDX_W-1:0] src_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             gen_ack_o,
  output logic             ie_o
);
  logic             trap_pend_w, va_pend_w;
  logic [NSRC-1:0]  cand_w, grant_w;
  logic             any_w, accept_w;
  logic [IDX_W-1:0] pick_w;

  irq_edge_latch #(.LEVEL_QUAL(1'b1)) u_trap_lat (
    .clk(clk), .rst_n(rst_n), .req_i(trap_req_i),
    .clr_i(accept_w & grant_w[SRC_TRAP]), .pend_o(trap_pend_w));

  irq_edge_latch #(.LEVEL_QUAL(1'b0)) u_va_lat (
    .clk(clk), .rst_n(rst_n), .req_i(vrq_a_i),
    .clr_i(accept_w & grant_w[SRC_VA]), .pend_o(va_pend_w));

  // trap is serviceable only while its line is still high
  assign cand_w[SRC_TRAP] = trap_pend_w & trap_req_i;
  assign cand_w[SRC_VA]   = va_pend_w   & ie_o;
  assign cand_w[SRC_VB]   = vrq_b_i     & ie_o;
  assign cand_w[SRC_VC]   = vrq_c_i     & ie_o;
  assign cand_w[SRC_GEN]  = gen_req_i   & ie_o;

  irq_prio_pick u_pick (
    .cand_i(cand_w), .any_o(any_w), .idx_o(pick_w), .grant_o(grant_w));

  assign accept_w = instr_end_i & any_w;

  irq_enable_ff u_ie (
    .clk(clk), .rst_n(rst_n), .set_i(en_instr_i), .clr_i(di_instr_i),
    .accept_i(accept_w), .ie_o(ie_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_o    <= 1'b0;
      src_o     <= '0;
      vec_o     <= '0;
      gen_ack_o <= 1'b0;
    end else begin
      take_o    <= accept_w;
      gen_ack_o <= accept_w & grant_w[SRC_GEN];
      if (accept_w) begin
        src_o <= pick_w;
        vec_o <= vec_of(pick_w);
      end
    end
  end

  // R1
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_w));
  // R5
  take_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(instr_end_i));
  // R4
  masked_only_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && src_o != SRC_TRAP) |-> $past(ie_o));
  // R10
  gen_ack_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gen_ack_o |-> (take_o && src_o == SRC_GEN));
  // R6
  no_take_with_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !ie_o);
endmodule

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en_i = 0, di_i = 0, end_i = 0, trap = 0, va = 0, vb = 0, vc = 0, gen = 0;
  logic take, gack, ie;
  logic [2:0] src;
  logic [7:0] vec;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .en_instr_i(en_i), .di_instr_i(di_i),
    .instr_end_i(end_i), .trap_req_i(trap), .vrq_a_i(va), .vrq_b_i(vb),
    .vrq_c_i(vc), .gen_req_i(gen), .take_o(take), .src_o(src), .vec_o(vec),
    .gen_ack_o(gack), .ie_o(ie));

  function automatic logic [7:0] exp_vec(input logic [2:0] i);
    case (i)
      3'd0: return 8'h24;
      3'd1: return 8'h3C;
      3'd2: return 8'h34;
      3'd3: return 8'h2C;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic do_reset(input logic trap_hi);
    rst_n = 0; en_i = 0; di_i = 0; end_i = 0;
    trap = trap_hi; va = 0; vb = 0; vc = 0; gen = 0;
    step(); step(); rst_n = 1; step();
  endtask

  task automatic enable(); en_i = 1; step(); en_i = 0; endtask
  task automatic boundary(); end_i = 1; step(); end_i = 0; endtask

  // {ie, trap, va, vb, vc, gen, exp_take, exp_src[2:0]}
  localparam logic [9:0] TBL [10] = '{
    10'b1_0_0_0_0_1_1_100, 10'b1_0_0_0_1_1_1_011, 10'b1_0_0_1_1_1_1_010,
    10'b1_0_1_1_1_1_1_001, 10'b1_1_1_1_1_1_1_000, 10'b0_0_1_1_1_1_0_000,
    10'b0_1_1_1_1_1_1_000, 10'b0_0_0_0_0_0_0_000, 10'b1_0_0_0_0_0_0_000,
    10'b1_0_1_0_0_1_1_001 };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    // R11 reset state
    do_reset(0);
    chk("R11 ie", ie, 0); chk("R11 take", take, 0); chk("R11 gack", gack, 0);
    boundary();
    chk("R11 no pending", take, 0);

    // R1 R2 R4 R10 R12 table walk
    foreach (TBL[e]) begin
      logic [9:0] t;
      t = TBL[e];
      do_reset(0);
      if (t[9]) enable();
      trap = t[8]; va = t[7]; vb = t[6]; vc = t[5]; gen = t[4];
      step();
      boundary();
      chk($sformatf("R1 R4 take e%0d", e), take, t[3]);
      if (t[3]) begin
        chk($sformatf("R1 src e%0d", e), src, t[2:0]);
        chk($sformatf("R2 vec e%0d", e), vec, exp_vec(t[2:0]));
        chk($sformatf("R10 gack e%0d", e), gack, t[2:0] == 3'd4);
        chk($sformatf("R6 ie e%0d", e), ie, 0);
      end else begin
        chk($sformatf("R10 gack idle e%0d", e), gack, 0);
      end
      trap = 0; va = 0; vb = 0; vc = 0; gen = 0;
      step();
      chk($sformatf("R12 take low e%0d", e), take, 0);
      chk($sformatf("R12 gack low e%0d", e), gack, 0);
    end

    // R3 enable flag strobes
    do_reset(0);
    enable();
    chk("R3 set", ie, 1);
    di_i = 1; step(); di_i = 0;
    chk("R3 clear", ie, 0);
    en_i = 1; di_i = 1; step(); en_i = 0; di_i = 0;
    chk("R3 disable wins", ie, 0);

    // R5 no take without boundary; R6 held level not retaken
    do_reset(0);
    enable();
    vc = 1;
    repeat (5) begin
      step();
      chk("R5 no boundary", take, 0);
    end
    end_i = 1; step();
    chk("R5 take", take, 1); chk("R5 src", src, 3); chk("R6 ie cleared", ie, 0);
    step(); end_i = 0;
    chk("R6 no retake", take, 0);
    vc = 0;

    // R7 trap high through reset is not an edge
    do_reset(1);
    boundary();
    chk("R7 level without edge", take, 0);
    trap = 0; step(); trap = 1; step();
    boundary();
    chk("R7 edge taken", take, 1); chk("R7 src", src, 0);
    step();
    boundary();
    chk("R7 latch cleared", take, 0);
    // R7 rise then fall before the boundary
    trap = 0; step(); trap = 1; step(); trap = 0;
    boundary();
    chk("R7 dropped trap", take, 0);

    // R8 edge held while disabled, held level not retaken
    do_reset(0);
    va = 1; step(); va = 0; step(); step();
    enable();
    boundary();
    chk("R8 pending held", take, 1); chk("R8 src", src, 1);
    va = 1; step();
    enable();
    boundary();
    chk("R8 second edge", take, 1);
    enable();
    boundary();
    chk("R8 held level no retake", take, 0);
    va = 0;

    // R9 level pulse gone before boundary
    do_reset(0);
    enable();
    vb = 1; step(); vb = 0;
    boundary();
    chk("R9 vb pulse", take, 0);
    gen = 1; step(); gen = 0;
    boundary();
    chk("R9 gen pulse", take, 0);
    chk("R9 ie kept", ie, 1);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule